// File: doc/BRIEF.md
# Aging Stress and Measurement Window Sequencer

This controller runs a long aging experiment on two arrays of ring oscillators. It alternates between a short measurement burst and a long stress interval. In the burst, both oscillator families run. In the stress interval, both are held stopped, so the only thing that ages the transistors is static bias at temperature, with no switching. One family is enabled by a high level and the other by a low level. The sequencer drives both of these controls from a single state, so they start and stop in the same clock cycle.

Around each burst, the sequencer clears the oscillation counters, lets them count for a fixed number of cycles, and pulses a capture strobe. It then raises a readout request and waits for the external readout-done handshake before it starts the next stress interval. Degradation changes fastest at the start of a run. For that reason the first stress dwell is short: it equals a programmable floor, for example 20 s. Each later dwell doubles the one before, until a programmable shift cap is reached. All timing is counted in clock cycles. The burst length is a plain cycle count, and the stress dwell is counted in ticks of a clock prescaler.

A step index counts the bursts of the current run. After the last step has been read out, the sequencer returns to idle. A new run can then be started.

Top module: `aging_window_seq`

## Requirements
- R1: After reset the outputs read as follows: `osc_en`=0, `osc_en_n`=1, `cnt_clr`=0, `cnt_cap`=0, `rd_req`=0, `step_idx`=0.
- R2: `osc_en_n` is always the inverse of `osc_en`. Both change in the same cycle.
- R3: If `start` is high in idle, `cnt_clr` is high for exactly one cycle in the next cycle. Every measurement burst is directly preceded by exactly one such clear cycle, during which `osc_en`=0.
- R4: Each measurement burst holds `osc_en`=1 for exactly `BURST_CYC` consecutive cycles.
- R5: `step_idx` rises by one in the first cycle of each burst. It is 0 during the first clear of a run, so the first burst of a run is step 1.
- R6: `cnt_cap` is high for exactly one cycle, in the first cycle after a burst ends. `rd_req` rises in the cycle after that.
- R7: `rd_req` stays high until `rd_done` is sampled high while the request is up. A `rd_done` pulse at any other time has no effect: the readout still happens and must still be acknowledged.
- R8: The stress interval after step k lasts exactly (`STRESS_BASE` << min(k-1, `MAX_SHIFT`)) × `TICK_DIV` cycles. It is measured from the first cycle after the acknowledgement to the next clear. Throughout the interval, `osc_en`=0 and `osc_en_n`=1.
- R9: After the acknowledgement of step `NUM_STEPS`, the sequencer goes idle. In idle it issues no clear, no enable and no request, and `step_idx` holds `NUM_STEPS`.
- R10: `start` is ignored outside idle. This includes a `start` that arrives in the same cycle as the final `rd_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| rd_done | input | 1 | Readout-done handshake |
| osc_en | output | 1 | Active-high enable, first oscillator family |
| osc_en_n | output | 1 | Active-low enable, complementary family |
| cnt_clr | output | 1 | One-cycle counter clear before each burst |
| cnt_cap | output | 1 | One-cycle counter capture after each burst |
| rd_req | output | 1 | Readout request, held until acknowledged |
| step_idx | output | $clog2(NUM_STEPS+1) | Index of the current or last burst |

## Verification
Two pairs of events can coincide in one cycle. The first pair is the acknowledgement of the final readout and a new `start`. The bench raises both together on the last step. It passes if the sequencer then stays idle for a long stretch, with no clear pulse. The second pair is a `start` that arrives in the middle of a stress dwell, and a `rd_done` pulse that arrives in the middle of a burst. The bench passes if neither one shortens the dwell, skips the readout or disturbs the step count. All dwell lengths are checked against the doubling schedule, computed arithmetically in the bench, and the schedule is run long enough to reach the shift cap.

// File: rtl/aws_pkg.sv
package aws_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CLEAR,
        S_MEAS,
        S_CAP,
        S_READ,
        S_STRESS
    } aws_state_e;

    typedef struct packed {
        logic osc_on;
        logic clr;
        logic cap;
        logic req;
    } aws_ctrl_t;

    // Shift applied to the dwell floor for the stress after step 'step'
    function automatic int unsigned aws_shift(int unsigned step, int unsigned cap);
        int unsigned s;
        s = (step == 0) ? 0 : step - 1;
        return (s > cap) ? cap : s;
    endfunction

    function automatic aws_ctrl_t aws_decode(aws_state_e st);
        aws_ctrl_t c;
        c.osc_on = (st == S_MEAS);
        c.clr    = (st == S_CLEAR);
        c.cap    = (st == S_CAP);
        c.req    = (st == S_READ);
        return c;
    endfunction

endpackage

// File: rtl/aws_prescaler.sv
module aws_prescaler #(
    parameter int unsigned DIV = 50
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic tick
);
    localparam int unsigned PW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(DIV - 1);

    logic [PW-1:0] cnt;

    assign tick = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/aws_timer.sv
module aws_timer #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         zero
);
    logic [W-1:0] cnt;

    assign zero = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val;
        end else if (dec) begin
            cnt <= cnt - 1'b1;
        end
    end
endmodule

// File: rtl/aws_fsm.sv
module aws_fsm
    import aws_pkg::*;
#(
    parameter int unsigned NUM_STEPS   = 8,
    parameter int unsigned BURST_CYC   = 600,
    parameter int unsigned STRESS_BASE = 20_000_000,
    parameter int unsigned MAX_SHIFT   = 6,
    parameter int unsigned TMR_W       = 32,
    parameter int unsigned STEP_W      = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              rd_done,
    input  logic              tick,
    input  logic              tmr_zero,
    output aws_state_e        state,
    output logic              tmr_load,
    output logic [TMR_W-1:0]  tmr_val,
    output logic              tmr_dec,
    output logic              pre_run,
    output logic [STEP_W-1:0] step_idx
);
    localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(NUM_STEPS);
    localparam logic [TMR_W-1:0]  BURST_LD  = TMR_W'(BURST_CYC - 1);

    logic             last_step;
    logic [TMR_W-1:0] dwell;

    assign last_step = (step_idx == LAST_STEP);
    assign dwell     = TMR_W'(STRESS_BASE) << aws_shift(32'(step_idx), MAX_SHIFT);

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= S_IDLE;
            step_idx <= '0;
        end else begin
            unique case (state)
                S_IDLE: if (start) begin
                    state    <= S_CLEAR;
                    step_idx <= '0;
                end
                S_CLEAR: begin
                    state    <= S_MEAS;
                    step_idx <= step_idx + 1'b1;
                end
                S_MEAS:   if (tmr_zero) state <= S_CAP;
                S_CAP:    state <= S_READ;
                S_READ:   if (rd_done) state <= last_step ? S_IDLE : S_STRESS;
                S_STRESS: if (tick && tmr_zero) state <= S_CLEAR;
                default:  state <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        tmr_load = (state == S_CLEAR) || (state == S_READ && rd_done && !last_step);
        tmr_val  = (state == S_CLEAR) ? BURST_LD : dwell - 1'b1;
        tmr_dec  = !tmr_zero && ((state == S_MEAS) || (state == S_STRESS && tick));
        pre_run  = (state == S_STRESS);
    end
endmodule

// File: rtl/aging_window_seq.sv
module aging_window_seq
    import aws_pkg::*;
#(
    parameter int unsigned TICK_DIV    = 50,
    parameter int unsigned BURST_CYC   = 600,
    parameter int unsigned STRESS_BASE = 20_000_000,
    parameter int unsigned MAX_SHIFT   = 6,
    parameter int unsigned NUM_STEPS   = 8
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           start,
    input  logic                           rd_done,
    output logic                           osc_en,
    output logic                           osc_en_n,
    output logic                           cnt_clr,
    output logic                           cnt_cap,
    output logic                           rd_req,
    output logic [$clog2(NUM_STEPS+1)-1:0] step_idx
);
    localparam int unsigned     STEP_W    = $clog2(NUM_STEPS + 1);
    localparam longint unsigned MAX_DWELL = longint'(STRESS_BASE) << MAX_SHIFT;
    localparam longint unsigned MAX_LOAD  = (MAX_DWELL > BURST_CYC) ? MAX_DWELL : BURST_CYC;
    localparam int unsigned     TMR_W     = $clog2(MAX_LOAD + 1);

    aws_state_e       state;
    aws_ctrl_t        ctrl;
    logic             tick, tmr_zero, tmr_load, tmr_dec, pre_run;
    logic [TMR_W-1:0] tmr_val;

    aws_fsm #(
        .NUM_STEPS  (NUM_STEPS),
        .BURST_CYC  (BURST_CYC),
        .STRESS_BASE(STRESS_BASE),
        .MAX_SHIFT  (MAX_SHIFT),
        .TMR_W      (TMR_W),
        .STEP_W     (STEP_W)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rd_done (rd_done),
        .tick    (tick),
        .tmr_zero(tmr_zero),
        .state   (state),
        .tmr_load(tmr_load),
        .tmr_val (tmr_val),
        .tmr_dec (tmr_dec),
        .pre_run (pre_run),
        .step_idx(step_idx)
    );

    aws_prescaler #(.DIV(TICK_DIV)) u_pre (
        .clk (clk),
        .rst (rst),
        .run (pre_run),
        .tick(tick)
    );

    aws_timer #(.W(TMR_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .load    (tmr_load),
        .load_val(tmr_val),
        .dec     (tmr_dec),
        .zero    (tmr_zero)
    );

    assign ctrl     = aws_decode(state);
    assign osc_en   = ctrl.osc_on;
    assign osc_en_n = !ctrl.osc_on;
    assign cnt_clr  = ctrl.clr;
    assign cnt_cap  = ctrl.cap;
    assign rd_req   = ctrl.req;
endmodule

// File: rtl/aws_checker.sv
module aws_checker #(
    parameter int unsigned BURST_CYC = 600,
    parameter int unsigned NUM_STEPS = 8
) (
    input logic                           clk,
    input logic                           rst,
    input logic                           osc_en,
    input logic                           cnt_clr,
    input logic                           cnt_cap,
    input logic                           rd_req,
    input logic                           rd_done,
    input logic [$clog2(NUM_STEPS+1)-1:0] step_idx
);
    localparam int unsigned SW = $clog2(NUM_STEPS + 1);

    logic [31:0] run_c;
    always_ff @(posedge clk) begin
        if (rst || !osc_en) run_c <= '0;
        else                run_c <= run_c + 1'b1;
    end

    assert_clr_then_meas_R3: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |-> !osc_en ##1 osc_en);

    assert_burst_len_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(osc_en) |-> (run_c == BURST_CYC));

    assert_step_inc_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(osc_en) |-> (step_idx == SW'($past(step_idx) + 1'b1)));

    assert_cap_after_burst_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(osc_en) |-> cnt_cap);

    assert_req_after_cap_R6: assert property (@(posedge clk) disable iff (rst)
        cnt_cap |=> rd_req);

    assert_req_held_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_done) |=> rd_req);
endmodule

bind aging_window_seq aws_checker #(
    .BURST_CYC(BURST_CYC),
    .NUM_STEPS(NUM_STEPS)
) u_chk (
    .clk     (clk),
    .rst     (rst),
    .osc_en  (osc_en),
    .cnt_clr (cnt_clr),
    .cnt_cap (cnt_cap),
    .rd_req  (rd_req),
    .rd_done (rd_done),
    .step_idx(step_idx)
);

// File: tb/aging_window_seq_tb.sv
module aging_window_seq_tb;
    localparam int unsigned DIV   = 4;
    localparam int unsigned BURST = 5;
    localparam int unsigned BASE  = 3;
    localparam int unsigned MAXSH = 2;
    localparam int unsigned N     = 5;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start = 1'b0;
    logic       rd_done = 1'b0;
    logic       osc_en, osc_en_n, cnt_clr, cnt_cap, rd_req;
    logic [2:0] step_idx;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    always #10 clk = ~clk;

    aging_window_seq #(
        .TICK_DIV   (DIV),
        .BURST_CYC  (BURST),
        .STRESS_BASE(BASE),
        .MAX_SHIFT  (MAXSH),
        .NUM_STEPS  (N)
    ) u_dut (
        .clk     (clk),
        .rst     (rst),
        .start   (start),
        .rd_done (rd_done),
        .osc_en  (osc_en),
        .osc_en_n(osc_en_n),
        .cnt_clr (cnt_clr),
        .cnt_cap (cnt_cap),
        .rd_req  (rd_req),
        .step_idx(step_idx)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int expect_dwell(int k);
        int s;
        s = (k - 1 > int'(MAXSH)) ? int'(MAXSH) : k - 1;
        return int'(BASE << s) * int'(DIV);
    endfunction

    // Caller leaves the bench at a negedge where the clear cycle is showing
    task automatic run_steps();
        for (int k = 1; k <= int'(N); k++) begin
            int run;
            int lat;
            int cnt;
            bit ok;
            chk(cnt_clr && !osc_en, "R3 clear before burst", cnt_clr, 1);
            chk(step_idx == k - 1, "R5 step during clear", step_idx, k - 1);
            @(negedge clk);
            chk(!cnt_clr, "R3 clear is one cycle", cnt_clr, 0);
            chk(step_idx == k, "R5 step at burst entry", step_idx, k);
            run = 0;
            ok  = 1'b1;
            while (osc_en && run < 1000) begin
                if (osc_en_n !== ~osc_en) ok = 1'b0;
                rd_done = (k == 3 && run == 2);  // early handshake, must be ignored (R7)
                run++;
                @(negedge clk);
            end
            rd_done = 1'b0;
            chk(ok, "R2 enable polarity in burst", ok, 1);
            chk(run == int'(BURST), "R4 burst length", run, BURST);
            chk(cnt_cap && !rd_req && osc_en_n, "R6 capture after burst", cnt_cap, 1);
            @(negedge clk);
            chk(rd_req && !cnt_cap, "R6 request after capture", rd_req, 1);
            lat = (k % 3) * 2;
            ok  = 1'b1;
            for (int i = 0; i < lat; i++) begin
                @(negedge clk);
                if (!rd_req) ok = 1'b0;
            end
            chk(ok, "R7 request held until done", ok, 1);
            rd_done = 1'b1;
            if (k == int'(N)) start = 1'b1;  // coincides with final handshake (R10)
            @(negedge clk);
            rd_done = 1'b0;
            start   = 1'b0;
            chk(!rd_req, "R7 request drops after done", rd_req, 0);
            if (k < int'(N)) begin
                cnt = 0;
                ok  = 1'b1;
                while (!cnt_clr && cnt < 100000) begin
                    if (osc_en || osc_en_n !== 1'b1) ok = 1'b0;
                    start = (k == 2 && cnt == 5);  // start mid-stress (R10)
                    cnt++;
                    @(negedge clk);
                end
                start = 1'b0;
                chk(ok, "R8 oscillators stopped in stress", ok, 1);
                chk(cnt == expect_dwell(k), "R8 stress dwell", cnt, expect_dwell(k));
                if (k == 2) chk(step_idx == 2, "R10 start ignored in stress", step_idx, 2);
            end else begin
                ok = 1'b1;
                for (int i = 0; i < 60; i++) begin
                    if (cnt_clr || osc_en || rd_req || !osc_en_n) ok = 1'b0;
                    @(negedge clk);
                end
                chk(ok, "R10 start with final done ignored", ok, 1);
                chk(ok, "R9 idle after last step", ok, 1);
                chk(step_idx == N, "R9 step held", step_idx, N);
            end
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!osc_en && osc_en_n && !cnt_clr && !cnt_cap && !rd_req && step_idx == 0,
            "R1 reset state", {osc_en, osc_en_n, cnt_clr, cnt_cap, rd_req}, 5'b01000);
        repeat (4) @(negedge clk);
        chk(!cnt_clr && !osc_en, "R10 no run without start", cnt_clr, 0);
        for (int r = 0; r < 2; r++) begin
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
            run_steps();
            repeat (3) @(negedge clk);
            // stray handshake in idle: no effect (R7)
            rd_done = 1'b1;
            @(negedge clk);
            rd_done = 1'b0;
            @(negedge clk);
            chk(!rd_req && !cnt_clr && step_idx == N, "R7 done ignored in idle", rd_req, 0);
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        for (int c = 0; c < 20000; c++) begin
            @(posedge clk);
            if (done) break;
        end
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end
endmodule